// File: doc/BRIEF.md
# Delay-Slot Program Counter Sequencer

This block steps the program counter for an instruction stream whose control transfers carry one delay slot. It holds a current fetch address and the address after it. On each issue step it takes the decoded transfer information for the instruction at the current address: whether it is a transfer at all, whether it is conditional, whether it is taken, the state of its annul bit, whether it is delayed, and the target address. From these it advances the address pair and decides whether the instruction that follows will run or be squashed.

Register-indirect jumps, calls and PC-relative branches all enter through the same supplied target. A separate non-delayed flag covers transfers such as a taken conditional trap, which redirect at once and override any delay-slot sequence still in progress. A squashed slot still uses one issue step. It is flagged with an annul strobe so that the pipeline lets it write no state. Its decoded inputs have no effect on the sequencing.

Top module: `delay_slot_seq`

## Requirements
- R1: While `rst` is high at a clock edge, the next state is `fetch_pc_o` = RESET_VEC, `next_pc_o` = RESET_VEC + INC and `annul_o` = 0.
- R2: A step with `annul_o` low and `cti_i` low moves `fetch_pc_o` to the old `next_pc_o` and `next_pc_o` to the old `next_pc_o` + INC.
- R3: A step with a taken delayed transfer (`cti_i`=1, `delayed_i`=1, `taken_i`=1) moves `fetch_pc_o` to the old `next_pc_o`, which is the delay slot, and moves `next_pc_o` to `target_i`. The step after the slot fetches the target.
- R4: A delayed transfer with `annul_bit_i` = 0 leaves `annul_o` low on the next step, whether it is taken or not and whether it is conditional or not.
- R5: A conditional delayed transfer (`cond_i`=1) with `annul_bit_i` = 1 raises `annul_o` on the next step if and only if `taken_i` = 0.
- R6: An unconditional delayed transfer (`cond_i`=0) with `annul_bit_i` = 1 always raises `annul_o` on the next step, whatever `taken_i` is.
- R7: A step with `annul_o` high uses exactly one step. It moves `fetch_pc_o` to the old `next_pc_o` and `next_pc_o` to the old `next_pc_o` + INC, clears `annul_o`, and ignores every transfer input.
- R8: A step with `annul_o` low and a taken non-delayed transfer (`cti_i`=1, `delayed_i`=0, `taken_i`=1) sets `fetch_pc_o` to `target_i`, sets `next_pc_o` to `target_i` + INC and clears `annul_o`. When this happens in a delay slot, it overrides the pending delayed target.
- R9: While `step_i` is low, `fetch_pc_o`, `next_pc_o` and `annul_o` hold their values.
- R10: A non-delayed transfer that is not taken steps sequentially, as in R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| step_i | input | 1 | Issue step for the instruction at `fetch_pc_o` |
| cti_i | input | 1 | Instruction is a control transfer |
| cond_i | input | 1 | Transfer is conditional (0 = unconditional) |
| taken_i | input | 1 | Transfer is taken |
| annul_bit_i | input | 1 | Annul bit of the transfer |
| delayed_i | input | 1 | Transfer has a delay slot (0 = takes effect at once) |
| target_i | input | AW | Target address (PC-relative or register-indirect) |
| fetch_pc_o | output | AW | Address of the instruction being issued |
| next_pc_o | output | AW | Address that follows it |
| annul_o | output | 1 | Instruction at `fetch_pc_o` is annulled and writes no state |

## Verification
The bench sweeps all sixteen combinations of conditional, taken, annul bit and delayed. Each combination is followed by a delay-slot instruction that is itself a taken immediate trap. This separates four outcomes: a slot that runs and whose trap overrides the delayed target, a slot that is squashed and whose trap is ignored, a taken target that is reached after the slot, and a fall-through. Sequential runs, a not-taken immediate transfer and stalled steps show that plain stepping and holding are kept apart from transfer handling.

// File: rtl/dbr_pkg.sv
package dbr_pkg;

  typedef enum logic [2:0] {
    ACT_SEQ,
    ACT_SLOT_TAKEN,
    ACT_SLOT_FALL,
    ACT_REDIRECT,
    ACT_SQUASH
  } dbr_act_e;

  typedef struct packed {
    logic cti;
    logic cond;
    logic taken;
    logic annul_bit;
    logic delayed;
  } xfer_t;

endpackage

// File: rtl/dbr_classify.sv
module dbr_classify
  import dbr_pkg::*;
(
  input  xfer_t    xfer_i,
  input  logic     slot_annulled_i,
  output dbr_act_e act_o,
  output logic     annul_next_o
);

  always_comb begin
    act_o        = ACT_SEQ;
    annul_next_o = 1'b0;
    if (slot_annulled_i) begin
      act_o = ACT_SQUASH;
    end else if (xfer_i.cti) begin
      if (!xfer_i.delayed) begin
        act_o = xfer_i.taken ? ACT_REDIRECT : ACT_SEQ;
      end else begin
        act_o        = xfer_i.taken ? ACT_SLOT_TAKEN : ACT_SLOT_FALL;
        // unconditional: annul bit always squashes; conditional: only when not taken
        annul_next_o = xfer_i.annul_bit & (~xfer_i.cond | ~xfer_i.taken);
      end
    end
  end

endmodule

// File: rtl/dbr_pc_regs.sv
module dbr_pc_regs
  import dbr_pkg::*;
#(
  parameter int AW = 32,
  parameter int INC = 4,
  parameter logic [AW-1:0] RESET_VEC = '0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          step_i,
  input  dbr_act_e      act_i,
  input  logic          annul_next_i,
  input  logic [AW-1:0] target_i,
  output logic [AW-1:0] pc_o,
  output logic [AW-1:0] npc_o,
  output logic          annul_o
);

  localparam logic [AW-1:0] STEP = AW'(INC);

  logic [AW-1:0] seq_addr;
  logic [AW-1:0] tgt_addr;

  assign seq_addr = npc_o + STEP;
  assign tgt_addr = target_i + STEP;

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_o    <= RESET_VEC;
      npc_o   <= RESET_VEC + STEP;
      annul_o <= 1'b0;
    end else if (step_i) begin
      annul_o <= annul_next_i;
      case (act_i)
        ACT_REDIRECT: begin
          pc_o  <= target_i;
          npc_o <= tgt_addr;
        end
        ACT_SLOT_TAKEN: begin
          pc_o  <= npc_o;
          npc_o <= target_i;
        end
        default: begin
          pc_o  <= npc_o;
          npc_o <= seq_addr;
        end
      endcase
    end
  end

endmodule

// File: rtl/delay_slot_seq.sv
module delay_slot_seq
  import dbr_pkg::*;
#(
  parameter int AW = 32,
  parameter int INC = 4,
  parameter logic [AW-1:0] RESET_VEC = '0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          step_i,
  input  logic          cti_i,
  input  logic          cond_i,
  input  logic          taken_i,
  input  logic          annul_bit_i,
  input  logic          delayed_i,
  input  logic [AW-1:0] target_i,
  output logic [AW-1:0] fetch_pc_o,
  output logic [AW-1:0] next_pc_o,
  output logic          annul_o
);

  xfer_t    xfer;
  dbr_act_e act;
  logic     annul_next;

  assign xfer = '{cti: cti_i, cond: cond_i, taken: taken_i,
                  annul_bit: annul_bit_i, delayed: delayed_i};

  dbr_classify u_classify (
    .xfer_i          (xfer),
    .slot_annulled_i (annul_o),
    .act_o           (act),
    .annul_next_o    (annul_next)
  );

  dbr_pc_regs #(
    .AW        (AW),
    .INC       (INC),
    .RESET_VEC (RESET_VEC)
  ) u_regs (
    .clk          (clk),
    .rst          (rst),
    .step_i       (step_i),
    .act_i        (act),
    .annul_next_i (annul_next),
    .target_i     (target_i),
    .pc_o         (fetch_pc_o),
    .npc_o        (next_pc_o),
    .annul_o      (annul_o)
  );

endmodule

// File: rtl/delay_slot_seq_chk.sv
module delay_slot_seq_chk #(
  parameter int AW = 32,
  parameter int INC = 4,
  parameter logic [AW-1:0] RESET_VEC = '0
) (
  input logic          clk,
  input logic          rst,
  input logic          step_i,
  input logic          cti_i,
  input logic          cond_i,
  input logic          taken_i,
  input logic          annul_bit_i,
  input logic          delayed_i,
  input logic [AW-1:0] target_i,
  input logic [AW-1:0] fetch_pc_o,
  input logic [AW-1:0] next_pc_o,
  input logic          annul_o
);

  localparam logic [AW-1:0] STEP = AW'(INC);

  p_reset_state_r1: assert property (@(posedge clk)
    rst |=> (fetch_pc_o == RESET_VEC) && (next_pc_o == RESET_VEC + STEP) && !annul_o);

  p_sequential_r2: assert property (@(posedge clk) disable iff (rst)
    (step_i && !annul_o && !cti_i) |=>
      (fetch_pc_o == $past(next_pc_o)) && (next_pc_o == $past(next_pc_o) + STEP));

  p_slot_then_target_r3: assert property (@(posedge clk) disable iff (rst)
    (step_i && !annul_o && cti_i && delayed_i && taken_i) |=>
      (fetch_pc_o == $past(next_pc_o)) && (next_pc_o == $past(target_i)));

  p_no_annul_clear_bit_r4: assert property (@(posedge clk) disable iff (rst)
    (step_i && !annul_o && cti_i && delayed_i && !annul_bit_i) |=> !annul_o);

  p_cond_annul_r5: assert property (@(posedge clk) disable iff (rst)
    (step_i && !annul_o && cti_i && delayed_i && cond_i && annul_bit_i) |=>
      (annul_o == !$past(taken_i)));

  p_uncond_annul_r6: assert property (@(posedge clk) disable iff (rst)
    (step_i && !annul_o && cti_i && delayed_i && !cond_i && annul_bit_i) |=> annul_o);

  p_squash_one_step_r7: assert property (@(posedge clk) disable iff (rst)
    (step_i && annul_o) |=>
      !annul_o && (fetch_pc_o == $past(next_pc_o)) && (next_pc_o == $past(next_pc_o) + STEP));

  p_immediate_redirect_r8: assert property (@(posedge clk) disable iff (rst)
    (step_i && !annul_o && cti_i && !delayed_i && taken_i) |=>
      !annul_o && (fetch_pc_o == $past(target_i)) && (next_pc_o == $past(target_i) + STEP));

  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !step_i |=> $stable(fetch_pc_o) && $stable(next_pc_o) && $stable(annul_o));

  p_not_taken_immediate_r10: assert property (@(posedge clk) disable iff (rst)
    (step_i && !annul_o && cti_i && !delayed_i && !taken_i) |=>
      !annul_o && (fetch_pc_o == $past(next_pc_o)));

endmodule

bind delay_slot_seq delay_slot_seq_chk #(
  .AW        (AW),
  .INC       (INC),
  .RESET_VEC (RESET_VEC)
) u_chk (.*);

// File: tb/delay_slot_seq_tb_top.sv
module delay_slot_seq_tb_top;

  localparam int AW = 16;
  localparam int INC = 4;
  localparam logic [AW-1:0] RV = 16'h0100;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic step_i = 1'b0, cti_i = 1'b0, cond_i = 1'b0, taken_i = 1'b0;
  logic annul_bit_i = 1'b0, delayed_i = 1'b0;
  logic [AW-1:0] target_i = '0;
  logic [AW-1:0] fetch_pc_o, next_pc_o;
  logic annul_o;

  int n_run = 0;
  int n_fail = 0;
  logic [AW-1:0] m_pc, m_npc;
  logic m_an;

  always #5 clk = ~clk;

  delay_slot_seq #(.AW(AW), .INC(INC), .RESET_VEC(RV)) dut_i (.*);

  task automatic compare(input string tag);
    n_run++;
    if (fetch_pc_o !== m_pc || next_pc_o !== m_npc || annul_o !== m_an) begin
      n_fail++;
      $display("FAIL %s: got pc=%h npc=%h an=%b exp pc=%h npc=%h an=%b",
               tag, fetch_pc_o, next_pc_o, annul_o, m_pc, m_npc, m_an);
    end
  endtask

  // drive one cycle, update model from requirements, check after the edge
  task automatic cyc(input logic st, input logic c, input logic cd, input logic tk,
                     input logic ab, input logic dl, input logic [AW-1:0] tg,
                     input string tag);
    @(negedge clk);
    step_i = st; cti_i = c; cond_i = cd; taken_i = tk;
    annul_bit_i = ab; delayed_i = dl; target_i = tg;
    if (st) begin
      if (m_an) begin                        // R7
        m_pc = m_npc; m_npc = m_npc + AW'(INC); m_an = 1'b0;
      end else if (c && !dl && tk) begin     // R8
        m_pc = tg; m_npc = tg + AW'(INC); m_an = 1'b0;
      end else if (c && dl) begin            // R3 R4 R5 R6
        m_pc = m_npc;
        m_npc = tk ? tg : m_npc + AW'(INC);
        m_an = ab && (cd ? !tk : 1'b1);
      end else begin                         // R2 R10
        m_pc = m_npc; m_npc = m_npc + AW'(INC); m_an = 1'b0;
      end
    end
    @(posedge clk);
    #2;
    compare(tag);
  endtask

  initial begin
    #200000;
    n_fail++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    m_pc = RV; m_npc = RV + AW'(INC); m_an = 1'b0;
    repeat (2) @(posedge clk);
    #2;
    compare("R1 reset");
    @(negedge clk);
    rst = 1'b0;
    cyc(1, 0, 0, 0, 0, 0, '0, "R2 seq a");
    cyc(1, 0, 1, 1, 1, 1, 16'h5550, "R2 seq b");
    cyc(0, 1, 0, 1, 0, 0, 16'h6660, "R9 hold");
    cyc(0, 1, 0, 1, 1, 1, 16'h6670, "R9 hold b");
    cyc(1, 1, 1, 0, 1, 0, 16'h6680, "R10 not taken immediate");
    for (int k = 0; k < 16; k++) begin
      logic cd, tk, ab, dl;
      string tg1;
      cd = k[0]; tk = k[1]; ab = k[2]; dl = k[3];
      if (!dl) tg1 = tk ? "R8 redirect" : "R10 fall";
      else if (!ab) tg1 = "R4 R3 clear bit";
      else if (cd) tg1 = "R5 R3 cond annul";
      else tg1 = "R6 R3 uncond annul";
      cyc(1, 1, cd, tk, ab, dl, AW'(16'h2000 + k * 16'h40), tg1);
      // delay-slot instruction is a taken immediate trap
      cyc(1, 1, 1, 1, 0, 0, AW'(16'h7000 + k * 16'h10),
          m_an ? "R7 squashed slot" : "R8 slot override");
      cyc(1, 0, 0, 0, 0, 0, '0, "R2 after");
      cyc(0, 0, 0, 0, 0, 0, '0, "R9 stall");
    end
    // taken delayed: slot runs then target fetched
    cyc(1, 1, 1, 1, 0, 1, 16'h3a00, "R3 taken");
    cyc(1, 0, 0, 0, 0, 0, '0, "R3 slot");
    cyc(1, 0, 0, 0, 0, 0, '0, "R3 at target");
    // reset mid-stream
    @(negedge clk);
    rst = 1'b1;
    m_pc = RV; m_npc = RV + AW'(INC); m_an = 1'b0;
    @(posedge clk);
    #2;
    compare("R1 re-reset");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule